// File: doc/BRIEF.md
# Shared Interrupt Target Routing Bank

This block keeps, for every shared interrupt of an interrupt distributor, the one CPU that the interrupt is delivered to. Software reaches it through a simple word-wide slave port. Each request carries a byte offset and the index of the CPU making the access. Each interrupt owns one byte of the address space, so four interrupts share one 32-bit word. The first 32 bytes belong to the per-CPU private interrupts. Those bytes are not stored. They always report the requesting CPU as the target.

When a shared word is written, each byte is reduced to a single CPU: the lowest set bit wins, and an all-zero byte means CPU 0. An interrupt therefore never has zero targets or several targets. A read returns each stored target as a one-hot byte. The block exports a flat bitmap with one row per CPU and one column per interrupt, for use by a separate forwarding block. It also raises a one-cycle strobe after every shared write so that downstream pending logic can re-evaluate.

Top module: `irq_route_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, every shared interrupt is routed to CPU 0. After that edge `upd_strobe` and `rsp_valid` are 0, and only the CPU 0 row of `route_map` is all ones.
- R2: A write to a shared word assigns each of its four bytes to the CPU whose index is the lowest set bit of that byte. Shared interrupt n sits at byte offset 32+n, in byte lane n mod 4 of its word. Bits at or above NUM_CPUS are disregarded.
- R3: A write byte with no usable bit set (all zero) routes its interrupt to CPU 0.
- R4: A read of a shared word returns, in byte lane k, a byte with only bit t set, where t is the stored CPU of the interrupt in lane k. The data appears with `rsp_valid` high in the cycle after the request.
- R5: A read at byte offsets 0 to 31 returns the byte (1 << `req_cpu`) repeated in all four lanes. A write there changes no route and raises no strobe.
- R6: `route_map` bit c*NUM_SHARED+n is 1 exactly when interrupt n is routed to CPU c. Every interrupt has exactly one bit set, and the map reflects a write in the cycle after it.
- R7: `upd_strobe` is high for the one cycle after each accepted write to a shared word, and low otherwise.
- R8: Offsets at or above 32+NUM_SHARED read as zero. Writes to them change nothing and raise no strobe.
- R9: `rsp_rdata` is zero in every cycle where `rsp_valid` is low.
- R10: A read issued in the cycle right after a write to the same word returns the newly written routes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset; the two low bits select no lane |
| req_cpu | input | 3 | Index of the requesting CPU |
| req_wdata | input | 32 | Write data, one target byte per lane |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| upd_strobe | output | 1 | One-cycle pulse after a shared write |
| route_map | output | NUM_CPUS*NUM_SHARED | Per-CPU target bitmap |

## Verification
A write and a read of the same word can meet: the read is presented in the cycle right after the write. The registered response must carry the new one-hot bytes while `upd_strobe` is high from that same write. The bench provokes this with back-to-back write/read pairs, both directed and random. It also uses back-to-back writes, which keep the strobe high for two cycles. A behavioural model updates its route table in request order and compares response data, strobe and the whole bitmap on every clock.

// File: rtl/irq_route_pkg.sv
// Package: shared constants and the byte-to-CPU reduction.
// Assumes at most 8 CPUs, so a CPU index fits in 3 bits.
package irq_route_pkg;

    localparam int CPU_IDX_W  = 3;
    localparam int PRIV_BYTES = 32;
    localparam int LANES      = 4;

    typedef logic [CPU_IDX_W-1:0] cpu_idx_t;

    // Lowest set bit among lanes below ncpu; CPU 0 when none is set.
    function automatic cpu_idx_t lowest_cpu(input logic [7:0] b, input int ncpu);
        cpu_idx_t r;
        r = '0;
        for (int k = 7; k >= 0; k--) begin
            if (k < ncpu && b[k]) r = cpu_idx_t'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_route_lane_pick.sv
// Reduces one byte of write data to a single CPU index.
// Purely combinational; assumes NUM_CPUS <= 8.
module irq_route_lane_pick #(
    parameter int NUM_CPUS = 8
) (
    input  logic [7:0]                  byte_in,
    output irq_route_pkg::cpu_idx_t     cpu_out
);
    // Pick the lowest usable set bit.
    always_comb cpu_out = irq_route_pkg::lowest_cpu(byte_in, NUM_CPUS);
endmodule

// File: rtl/irq_route_store.sv
// Holds one CPU index per shared interrupt. A write replaces the four
// indices of the addressed word. Assumes wr_word is in range whenever
// wr_en is high.
module irq_route_store #(
    parameter int NUM_SHARED = 32,
    parameter int WORD_W     = 6
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [WORD_W-1:0]                      wr_word,
    input  logic [4*irq_route_pkg::CPU_IDX_W-1:0]  wr_idx,
    output logic [NUM_SHARED*irq_route_pkg::CPU_IDX_W-1:0] tgt_flat
);
    localparam int IW = irq_route_pkg::CPU_IDX_W;

    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_irq
        // Reset routes to CPU 0; a matching write loads this lane's index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tgt_flat[i*IW +: IW] <= '0;
            else if (wr_en && wr_word == WORD_W'(i/4))
                tgt_flat[i*IW +: IW] <= wr_idx[(i%4)*IW +: IW];
        end
    end
endmodule

// File: rtl/irq_route_map.sv
// Expands the stored CPU indices into a per-CPU interrupt bitmap.
// Row c holds the interrupts routed to CPU c.
module irq_route_map #(
    parameter int NUM_CPUS   = 8,
    parameter int NUM_SHARED = 32
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [NUM_SHARED*irq_route_pkg::CPU_IDX_W-1:0] tgt_flat,
    output logic [NUM_CPUS*NUM_SHARED-1:0]                 route_map
);
    localparam int IW = irq_route_pkg::CPU_IDX_W;

    for (genvar i = 0; i < NUM_SHARED; i++) begin : g_col
        logic [NUM_CPUS-1:0] col;
        for (genvar c = 0; c < NUM_CPUS; c++) begin : g_row
            // Decode: interrupt i belongs to CPU c.
            assign col[c] = (tgt_flat[i*IW +: IW] == IW'(c));
            assign route_map[c*NUM_SHARED + i] = col[c];
        end

        // R6
        one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) == 1);
    end
endmodule

// File: rtl/irq_route_bank.sv
// Top of the shared interrupt target routing bank. It decodes word accesses,
// writes converted targets, answers reads one cycle later, pulses the update
// strobe and exports the routing bitmap. Assumes NUM_SHARED is a multiple
// of 4, NUM_CPUS <= 8, and 32+NUM_SHARED < 2**ADDR_W.
module irq_route_bank #(
    parameter int NUM_CPUS   = 8,
    parameter int NUM_SHARED = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [2:0]                     req_cpu,
    input  logic [31:0]                    req_wdata,
    output logic                           rsp_valid,
    output logic [31:0]                    rsp_rdata,
    output logic                           upd_strobe,
    output logic [NUM_CPUS*NUM_SHARED-1:0] route_map
);
    import irq_route_pkg::*;

    localparam int IW     = CPU_IDX_W;
    localparam int LIMIT  = PRIV_BYTES + NUM_SHARED;
    localparam int WORD_W = ADDR_W - 2;

    logic                     is_priv, is_shared, do_write;
    logic [WORD_W-1:0]        sh_word;
    logic [LANES*IW-1:0]      pick_idx;
    logic [NUM_SHARED*IW-1:0] tgt_flat;
    logic [31:0]              rd_comb;

    // Classify the offset and form the shared word index.
    always_comb begin
        is_priv   = ({1'b0, req_addr} < (ADDR_W+1)'(PRIV_BYTES));
        is_shared = !is_priv && ({1'b0, req_addr} < (ADDR_W+1)'(LIMIT));
        sh_word   = req_addr[ADDR_W-1:2] - WORD_W'(PRIV_BYTES/4);
        do_write  = req_valid && req_write && is_shared;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        irq_route_lane_pick #(.NUM_CPUS(NUM_CPUS)) u_pick (
            .byte_in (req_wdata[l*8 +: 8]),
            .cpu_out (pick_idx[l*IW +: IW])
        );
    end

    irq_route_store #(.NUM_SHARED(NUM_SHARED), .WORD_W(WORD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (do_write),
        .wr_word  (sh_word),
        .wr_idx   (pick_idx),
        .tgt_flat (tgt_flat)
    );

    irq_route_map #(.NUM_CPUS(NUM_CPUS), .NUM_SHARED(NUM_SHARED)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgt_flat  (tgt_flat),
        .route_map (route_map)
    );

    // Build read data: private repeats the requester, shared encodes targets.
    always_comb begin
        rd_comb = '0;
        if (is_priv) begin
            rd_comb = {4{8'(8'd1 << req_cpu)}};
        end else if (is_shared) begin
            for (int l = 0; l < LANES; l++) begin
                rd_comb[l*8 +: 8] =
                    8'(8'd1 << tgt_flat[(int'(sh_word)*LANES + l)*IW +: IW]);
            end
        end
    end

    // Register the response and the update strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_rdata  <= '0;
            upd_strobe <= 1'b0;
        end else begin
            rsp_valid  <= req_valid && !req_write;
            rsp_rdata  <= (req_valid && !req_write) ? rd_comb : '0;
            upd_strobe <= do_write;
        end
    end

    // R7
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> $past(req_valid && req_write && is_shared));

    // R4
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    // R5
    inert_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !is_shared) |=> ($stable(route_map) && !upd_strobe));

    // R9
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_rdata == '0));
endmodule

// File: tb/irq_route_bank_tb.sv
module irq_route_bank_tb;
    localparam int NC = 8;
    localparam int NS = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_cpu = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          upd_strobe;
    logic [NC*NS-1:0] route_map;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    irq_route_bank #(.NUM_CPUS(NC), .NUM_SHARED(NS), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_cpu(req_cpu), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .upd_strobe(upd_strobe),
        .route_map(route_map)
    );

    // Behavioural model state
    int          ref_tgt [NS];
    logic        e_valid, e_strobe;
    logic [31:0] e_rdata;
    logic [NC*NS-1:0] e_map;

    function automatic int pick(input logic [7:0] b);
        for (int k = 0; k < NC; k++) if (b[k]) return k;
        return 0;
    endfunction

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Model step and comparison on every clock
    always @(posedge clk) begin
        logic s_rst, s_v, s_w;
        logic [AW-1:0] s_a;
        logic [2:0] s_c;
        logic [31:0] s_d;
        string rtag;
        s_rst = rst_n; s_v = req_valid; s_w = req_write;
        s_a = req_addr; s_c = req_cpu; s_d = req_wdata;
        #1;
        rtag = "R9";
        if (!s_rst) begin
            for (int i = 0; i < NS; i++) ref_tgt[i] = 0;
            e_valid = 0; e_strobe = 0; e_rdata = 0;
        end else begin
            e_valid = s_v && !s_w;
            e_rdata = 0;
            e_strobe = 0;
            if (s_v) begin
                if (s_a < 32) begin
                    if (!s_w) begin e_rdata = {4{8'(8'd1 << s_c)}}; rtag = "R5"; end
                end else if (s_a < 32 + NS) begin
                    int base;
                    base = ((int'(s_a) - 32) / 4) * 4;
                    if (!s_w) begin
                        for (int l = 0; l < 4; l++)
                            e_rdata[l*8 +: 8] = 8'(8'd1 << ref_tgt[base+l]);
                        rtag = "R4";
                    end else begin
                        for (int l = 0; l < 4; l++)
                            ref_tgt[base+l] = pick(s_d[l*8 +: 8]);
                        e_strobe = 1;
                    end
                end else if (!s_w) rtag = "R8";
            end
        end
        for (int c = 0; c < NC; c++)
            for (int i = 0; i < NS; i++)
                e_map[c*NS+i] = (ref_tgt[i] == c);
        chk(s_rst ? "R6 route_map" : "R1 route_map", 256'(route_map), 256'(e_map));
        chk(s_rst ? "R7 upd_strobe" : "R1 upd_strobe", 256'(upd_strobe), 256'(e_strobe));
        chk(s_rst ? "R4 rsp_valid" : "R1 rsp_valid", 256'(rsp_valid), 256'(e_valid));
        chk({rtag, " rsp_rdata"}, 256'(rsp_rdata), 256'(e_rdata));
    end

    task automatic op(input logic w, input int a, input int c, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a);
        req_cpu = 3'(c); req_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Directed check of the response to the read just issued.
    task automatic expect_rd(input string tag, input logic [31:0] exp);
        @(posedge clk); #2;
        chk(tag, 256'(rsp_rdata), 256'(exp));
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset routes read back as CPU 0
        op(0, 32, 0, 0);  expect_rd("R1 reset route", 32'h01010101);
        op(0, 60, 3, 0);  expect_rd("R1 reset route top", 32'h01010101);
        // R5 private reads per requester
        for (int c = 0; c < NC; c++) begin
            op(0, 4*(c%8), c, 0);
            expect_rd("R5 private read", {4{8'(8'd1 << c)}});
        end
        // R2 lowest set bit per lane
        op(1, 36, 0, 32'hFF00C006); idle();
        op(0, 37, 0, 0); expect_rd("R2 lane pick", 32'h01014002);
        op(1, 40, 0, 32'h80402010); idle();
        op(0, 40, 0, 0); expect_rd("R2 single bits", 32'h80402010);
        // R3 zero byte goes to CPU 0
        op(1, 40, 0, 32'h00000000); idle();
        op(0, 40, 0, 0); expect_rd("R3 zero bytes", 32'h01010101);
        // R5 private write ignored
        op(1, 8, 2, 32'h80808080); idle();
        op(0, 8, 2, 0); expect_rd("R5 private write ignored", 32'h04040404);
        // R8 out of range
        op(1, 64, 0, 32'h80808080); idle();
        op(0, 64, 0, 0); expect_rd("R8 out of range read", 32'h0);
        op(0, 36, 0, 0); expect_rd("R8 no side effect", 32'h01014002);
        // R10 read right after write, also back-to-back writes (R7)
        op(1, 44, 0, 32'h08040201);
        op(1, 48, 0, 32'h10101010);
        op(0, 48, 5, 0); expect_rd("R10 read after write", 32'h10101010);
        op(0, 44, 5, 0); expect_rd("R10 earlier word", 32'h08040201);
        // Random traffic
        for (int k = 0; k < 600; k++) begin
            int a;
            a = int'($urandom_range(0, 70));
            op($urandom_range(0, 1) == 1, a, int'($urandom_range(0, 7)), $urandom());
            if ($urandom_range(0, 3) == 0) idle();
        end
        // R1 mid-run reset
        idle();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        op(0, 52, 0, 0); expect_rd("R1 route after reset", 32'h01010101);
        idle(); idle();
        finish_run();
    end
endmodule